// File: doc/BRIEF.md
# Programmable External Memory Read Sequencer

This block runs read accesses to an external asynchronous static memory on a 16-bit parallel bus. A request carries a byte address, a chip-select index and a width flag that marks the device as 8-bit or 16-bit. Once a request is accepted, the block drives the address and byte-select lines for the whole access. It drives an active-low read strobe and one of six active-low chip selects. Each of the two strobes has its own setup and pulse counts in controller clock cycles. A single programmable cycle length bounds the whole access.

Each strobe's hold time is whatever is left of the cycle length after its setup and pulse. The strobe rises at the end of its pulse, or at the end of the access if that comes first. The block samples the data bus on the clock edge where the read strobe rises and returns the value with a one-cycle valid pulse. A new request is taken only when no access is in progress.

Top module: `mem_read_sequencer`

## Requirements
- R1: Out of reset and whenever no access is running, `req_ready` is 1, `mem_rd_n` is 1, all `mem_cs_n` bits are 1, `mem_bsel_n` is 2'b11, `mem_addr` is 0, and `rsp_valid` is 0.
- R2: Access cycles are numbered from 0, and cycle 0 is the first cycle after the accepting clock edge. With setup S and pulse P', where P' is the pulse count or 1 when that count is zero, `mem_rd_n` is 0 exactly in cycles S to S+P'-1 that fall inside the access.
- R3: The chip select follows the same window rule with its own setup and pulse counts. Only bit `req_cs` of `mem_cs_n` goes low, and index values 6 and 7 assert no chip select.
- R4: A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are 1. The access then lasts L cycles, where L is `cfg_cycle_len`, or 1 when that value is zero. `req_ready` stays 0 for those L cycles whatever `req_valid` and the request fields do. The address, index and width latched at acceptance are the ones used for the whole access.
- R5: With `req_wide`=0 (8-bit device), `mem_addr` carries the full byte address, bits 1 and 0 included, and `mem_bsel_n` stays 2'b11 during the access.
- R6: With `req_wide`=1 (16-bit device), `mem_addr` carries the address with bit 0 forced to 0, and `mem_bsel_n` is 2'b00 (both lanes) during the access.
- R7: `mem_data_in` is sampled on the edge that ends the last cycle of the read-strobe pulse, or on the edge that ends the access when that edge comes first or the strobe never went low. `rsp_valid` is 1 for exactly the one cycle that follows that edge.
- R8: In 16-bit mode `rsp_data` is the whole sampled bus. In 8-bit mode it is {8'h00, sampled bits 7:0}.
- R9: When setup plus pulse reaches past the end of the access, the strobe or chip select is released as soon as the access ends. A zero pulse count still gives a low pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_setup | input | CW | Read-strobe setup count |
| cfg_rd_pulse | input | CW | Read-strobe pulse count (0 acts as 1) |
| cfg_cs_setup | input | CW | Chip-select setup count |
| cfg_cs_pulse | input | CW | Chip-select pulse count (0 acts as 1) |
| cfg_cycle_len | input | CW | Total access length (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Byte address |
| req_cs | input | SW | Chip-select index |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| mem_addr | output | AW | External address lines |
| mem_bsel_n | output | 2 | Active-low byte-lane selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_data_in | input | DW | External data bus |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DW | Returned read data |

## Verification
The assertions assume that the timing inputs stay constant for the length of an access, and that request fields only matter at the accepting edge. They also assume that the data bus is a plain input and never feeds back into the strobe timing. The stimulus changes the timing inputs only when `req_ready` is high and no access is running. During an access it keeps `req_valid` high and scrambles the address, so the hold-off and latching rules are tested at the ports without breaking those assumptions.

// File: rtl/ers_pkg.sv
package ers_pkg;
  localparam int EXT_W = 16;
  typedef logic [EXT_W-1:0] ext_t;

  function automatic ext_t at_least_one(input ext_t v);
    return (v == ext_t'(0)) ? ext_t'(1) : v;
  endfunction

  function automatic logic in_window(input ext_t k, input ext_t s, input ext_t p);
    return (k >= s) && (k < s + at_least_one(p));
  endfunction

  function automatic logic window_tail(input ext_t k, input ext_t s, input ext_t p);
    return k == (s + at_least_one(p) - ext_t'(1));
  endfunction
endpackage

// File: rtl/ers_window.sv
module ers_window
  import ers_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic last_i,
  input  ext_t cnt_i,
  input  ext_t setup_i,
  input  ext_t pulse_i,
  output logic active_o,
  output logic end_o
);
  assign active_o = busy_i && in_window(cnt_i, setup_i, pulse_i);
  assign end_o    = active_o && (window_tail(cnt_i, setup_i, pulse_i) || last_i);

  // R2 / R3: an active strobe continues until its end cycle
  a_r2_hold_until_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !end_o) |=> active_o);
  // R2 / R9: the cycle after an end cycle is released
  a_r9_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !active_o);
endmodule

// File: rtl/ers_addr_fmt.sv
module ers_addr_fmt #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          wide_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    bsel_n_o
);
  always_comb begin
    addr_o   = '0;
    bsel_n_o = 2'b11;
    if (en_i) begin
      if (wide_i) begin
        addr_o   = {addr_i[AW-1:1], 1'b0};
        bsel_n_o = 2'b00;
      end else begin
        addr_o   = addr_i;
      end
    end
  end

  a_r6_wide_bit0_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wide_i) |-> (addr_o[0] == 1'b0 && addr_o[AW-1:1] == addr_i[AW-1:1]));
  a_r5_narrow_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wide_i) |-> (bsel_n_o == 2'b11 && addr_o == addr_i));
endmodule

// File: rtl/ers_cs_dec.sv
module ers_cs_dec #(
  parameter int NCS = 6,
  parameter int SW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [SW-1:0]  idx_i,
  output logic [NCS-1:0] cs_n_o
);
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n_o[i] = !(en_i && (idx_i == SW'(i)));
  end

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));
  a_r3_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (&cs_n_o));
endmodule

// File: rtl/mem_read_sequencer.sv
module mem_read_sequencer
  import ers_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int NCS = 6,
  parameter int CW  = 6,
  localparam int SW = (NCS > 1) ? $clog2(NCS + 1) : 1,
  localparam int HW = DW / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cfg_rd_setup,
  input  logic [CW-1:0]  cfg_rd_pulse,
  input  logic [CW-1:0]  cfg_cs_setup,
  input  logic [CW-1:0]  cfg_cs_pulse,
  input  logic [CW-1:0]  cfg_cycle_len,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [SW-1:0]  req_cs,
  input  logic           req_wide,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_bsel_n,
  output logic           mem_rd_n,
  output logic [NCS-1:0] mem_cs_n,
  input  logic [DW-1:0]  mem_data_in,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data
);
  logic          busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] cs_q;
  logic          wide_q;
  logic          got_q;

  ext_t cnt_x, len_x;
  logic last, accept, sample;
  logic rd_active, rd_end, cs_active, cs_end;

  assign cnt_x     = ext_t'(cnt);
  assign len_x     = at_least_one(ext_t'(cfg_cycle_len));
  assign last      = busy && (cnt_x == len_x - ext_t'(1));
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign sample    = busy && !got_q && (rd_end || last);

  ers_window i_rd_win (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .last_i(last), .cnt_i(cnt_x),
    .setup_i(ext_t'(cfg_rd_setup)), .pulse_i(ext_t'(cfg_rd_pulse)),
    .active_o(rd_active), .end_o(rd_end)
  );

  ers_window i_cs_win (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .last_i(last), .cnt_i(cnt_x),
    .setup_i(ext_t'(cfg_cs_setup)), .pulse_i(ext_t'(cfg_cs_pulse)),
    .active_o(cs_active), .end_o(cs_end)
  );

  ers_addr_fmt #(.AW(AW)) i_addr (
    .clk(clk), .rst_n(rst_n), .en_i(busy), .wide_i(wide_q), .addr_i(addr_q),
    .addr_o(mem_addr), .bsel_n_o(mem_bsel_n)
  );

  ers_cs_dec #(.NCS(NCS), .SW(SW)) i_csdec (
    .clk(clk), .rst_n(rst_n), .en_i(cs_active), .idx_i(cs_q), .cs_n_o(mem_cs_n)
  );

  assign mem_rd_n = !rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      addr_q    <= '0;
      cs_q      <= '0;
      wide_q    <= 1'b0;
      got_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) begin
        got_q    <= 1'b1;
        rsp_data <= wide_q ? mem_data_in : {{(DW-HW){1'b0}}, mem_data_in[HW-1:0]};
      end
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= '0;
        addr_q <= req_addr;
        cs_q   <= req_cs;
        wide_q <= req_wide;
        got_q  <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (last) busy <= 1'b0;
      end
    end
  end

  a_r4_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_cycle_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (mem_rd_n && (&mem_cs_n) && req_ready));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r7_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && !got_q) ##1 mem_rd_n |-> rsp_valid);
  a_r3_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (&mem_cs_n));
endmodule

// File: tb/test_mem_read_sequencer.sv
module test_mem_read_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [5:0]  sr;
    logic [5:0]  pr;
    logic [5:0]  sc;
    logic [5:0]  pc;
    logic [5:0]  len;
    logic [23:0] addr;
    logic [2:0]  cs;
    logic        wide;
    logic [15:0] base;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{6'd1, 6'd2, 6'd0, 6'd4, 6'd5, 24'h123457, 3'd0, 1'b0, 16'hA5C3},
    '{6'd2, 6'd3, 6'd1, 6'd5, 6'd8, 24'h00ABCD, 3'd3, 1'b1, 16'h5A17},
    '{6'd0, 6'd0, 6'd0, 6'd0, 6'd1, 24'hFFFFFF, 3'd5, 1'b1, 16'h0F0F},
    '{6'd3, 6'd4, 6'd2, 6'd6, 6'd5, 24'h000002, 3'd1, 1'b0, 16'h1234},
    '{6'd6, 6'd1, 6'd0, 6'd1, 6'd4, 24'h800001, 3'd7, 1'b1, 16'hBEEF},
    '{6'd0, 6'd5, 6'd0, 6'd0, 6'd6, 24'h00FF00, 3'd2, 1'b0, 16'h7E81},
    '{6'd0, 6'd1, 6'd0, 6'd1, 6'd0, 24'h0000A3, 3'd4, 1'b0, 16'hC001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_rd_setup = '0, cfg_rd_pulse = '0, cfg_cs_setup = '0;
  logic [5:0]  cfg_cs_pulse = '0, cfg_cycle_len = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [2:0]  req_cs = '0;
  logic        req_wide = 1'b0;
  logic [23:0] mem_addr;
  logic [1:0]  mem_bsel_n;
  logic        mem_rd_n;
  logic [5:0]  mem_cs_n;
  logic [15:0] mem_data_in = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_read_sequencer i_mem_read_sequencer (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
    .cfg_cycle_len(cfg_cycle_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cs(req_cs), .req_wide(req_wide),
    .mem_addr(mem_addr), .mem_bsel_n(mem_bsel_n), .mem_rd_n(mem_rd_n),
    .mem_cs_n(mem_cs_n), .mem_data_in(mem_data_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk({tag, " ready"}, 32'(req_ready), 32'd1);
    chk({tag, " rd_n"}, 32'(mem_rd_n), 32'd1);
    chk({tag, " cs_n"}, 32'(mem_cs_n), 32'h3F);
    chk({tag, " bsel_n"}, 32'(mem_bsel_n), 32'd3);
    chk({tag, " addr"}, 32'(mem_addr), 32'd0);
  endtask

  function automatic int one_min(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    idle_outputs("R1 reset");
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_outputs("R1 idle");

    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VEC[v];
      automatic int L   = one_min(int'(t.len));
      automatic int rpe = int'(t.sr) + one_min(int'(t.pr));
      automatic int cpe = int'(t.sc) + one_min(int'(t.pc));
      automatic int ks  = (rpe - 1 < L - 1) ? rpe - 1 : L - 1;
      automatic logic [15:0] dsm = t.base ^ 16'(ks);
      automatic logic [15:0] dexp = t.wide ? dsm : {8'h00, dsm[7:0]};
      automatic logic [23:0] aexp = t.wide ? {t.addr[23:1], 1'b0} : t.addr;
      automatic string rtag = (rpe > L || t.pr == 0) ? "R9 rd" : "R2 rd";
      automatic string ctag = (cpe > L || t.pc == 0) ? "R9 cs" : "R3 cs";
      automatic string atag = t.wide ? "R6" : "R5";
      @(negedge clk);
      cfg_rd_setup  = t.sr;
      cfg_rd_pulse  = t.pr;
      cfg_cs_setup  = t.sc;
      cfg_cs_pulse  = t.pc;
      cfg_cycle_len = t.len;
      req_addr  = t.addr;
      req_cs    = t.cs;
      req_wide  = t.wide;
      req_valid = 1'b1;
      for (int k = 0; k <= L; k++) begin
        @(negedge clk);
        mem_data_in = t.base ^ 16'(k);
        if (k == 0) begin
          // R4: scramble the request while the access runs
          req_addr = ~t.addr;
          req_cs   = t.cs + 3'd1;
          req_wide = ~t.wide;
        end
        #1;
        if (k < L) begin
          automatic logic rd_low = (k >= int'(t.sr)) && (k < rpe);
          automatic logic cs_on  = (k >= int'(t.sc)) && (k < cpe) && (t.cs < 3'd6);
          automatic logic [5:0] cexp = cs_on ? ~(6'b1 << t.cs) : 6'h3F;
          chk(rtag, 32'(mem_rd_n), 32'(!rd_low));
          chk(ctag, 32'(mem_cs_n), 32'(cexp));
          chk({atag, " addr"}, 32'(mem_addr), 32'(aexp));
          chk({atag, " bsel_n"}, 32'(mem_bsel_n), t.wide ? 32'd0 : 32'd3);
          chk("R4 ready low", 32'(req_ready), 32'd0);
        end else begin
          idle_outputs("R4 R9 end of access");
          req_valid = 1'b0;
        end
        chk("R7 rsp_valid", 32'(rsp_valid), 32'(k == ks + 1));
        if (k == ks + 1) chk("R8 rsp_data", 32'(rsp_data), 32'(dexp));
      end
    end

    @(negedge clk);
    chk("R1 idle after runs rsp_valid", 32'(rsp_valid), 32'd0);
    idle_outputs("R1 idle after runs");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule